// File: doc/BRIEF.md
# Memory Access Fault Classifier

This block sits next to a load, store and instruction-fetch pipeline. It classifies each memory request, one per cycle, as clean, address-misaligned or access-fault. A request carries its kind (fetch, load, load-reserved, store, store-conditional or atomic read-modify-write), the privilege level it runs at, its virtual address and its size. It also carries what the surrounding logic already knows about the target region: whether a protection entry matched, the read, write and execute permissions of that entry, and whether the region is non-idempotent.

One cycle after the request, the block raises a single-cycle exception strobe together with a cause code. On every exception it loads the virtual address of the request into a trap value register. That register holds its value until the next exception. Protection-entry matching, address translation, the splitting of misaligned accesses and trap handling all happen outside the block.

Top module: `mem_fault_classifier`

## Requirements
- R1: `exc_valid_o` is high in the cycle after a cycle with `req_valid_i` high whose request faults, and low at every other time. Reset clears `exc_valid_o`, `exc_cause_o` and `exc_tval_o` to zero.
- R2: A request is misaligned when the low `req_size_i` bits of `req_vaddr_i` are not all zero. The size code is log2 of the byte count: 0 is 1 byte, 1 is 2, 2 is 4 and 3 is 8.
- R3: A misaligned fetch, load or store that is not atomic and targets an idempotent region reports address-misaligned (cause 0, 4 or 6 by class). This takes priority over any permission failure.
- R4: A misaligned load-reserved, store-conditional or atomic read-modify-write reports access-fault (cause 5 or 7), even when a permission failure also applies. Exactly one exception is raised.
- R5: A misaligned request of any kind to a region with `region_non_idem_i` high reports access-fault of its class (1, 5 or 7).
- R6: An aligned fetch to a matched region with `region_x_i` low reports cause 1.
- R7: An aligned load or load-reserved to a matched region with `region_r_i` low reports cause 5.
- R8: An aligned store, store-conditional or atomic read-modify-write to a matched region with `region_w_i` low reports cause 7, whether or not the conditional store would have succeeded.
- R9: With `PROT_ENTRIES` greater than 0 and `region_hit_i` low, supervisor requests (priv 1) and user requests (priv 0) fault with access-fault, and machine-mode requests (priv 3) pass.
- R10: With `PROT_ENTRIES` equal to 0, permissions and region match are ignored, and only misalignment raises exceptions.
- R11: On every exception `exc_tval_o` takes the faulting `req_vaddr_i`. Without an exception it holds its value.
- R12: The cause codes are: instruction misaligned 0, instruction access-fault 1, load misaligned 4, load access-fault 5, store misaligned 6, store access-fault 7. The kind encodings are fetch 0, load 1, load-reserved 2, store 3, store-conditional 4, atomic 5. `exc_cause_o` holds its value between exceptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_type_i | input | 3 | Access kind (R12 encoding) |
| req_priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_vaddr_i | input | VA_W | Virtual address of the request |
| req_size_i | input | SIZE_W | log2 of access size in bytes |
| region_hit_i | input | 1 | A protection entry matched |
| region_r_i | input | 1 | Matched entry grants read |
| region_w_i | input | 1 | Matched entry grants write |
| region_x_i | input | 1 | Matched entry grants execute |
| region_non_idem_i | input | 1 | Target region is non-idempotent |
| exc_valid_o | output | 1 | Exception strobe, one cycle after the request |
| exc_cause_o | output | 4 | Cause code of the last exception |
| exc_tval_o | output | VA_W | Virtual address of the last exception |

## Verification
The bench builds two copies of the block side by side: `u_dut` uses the default of 16 protection entries, and `u_dut_open` uses none. Both copies get the same request stream. The first copy exercises permission and no-match behaviour for all three privilege levels. The second shows that the same misalignment decisions remain when the permission path is removed, which brings R10 into reach. Address width is 39 bits and maximum size is 8 bytes, so every size code and offset combination can be reached.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [2:0] {
    ACC_FETCH = 3'd0,
    ACC_LOAD  = 3'd1,
    ACC_LR    = 3'd2,
    ACC_STORE = 3'd3,
    ACC_SC    = 3'd4,
    ACC_AMO   = 3'd5
  } acc_type_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    CLS_INSTR = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2
  } fault_cls_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  localparam logic [CAUSE_W-1:0] CAUSE_I_MIS = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_I_ACC = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_L_MIS = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_L_ACC = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_S_MIS = 4'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_S_ACC = 4'd7;
endpackage

// File: rtl/mfc_align_chk.sv
module mfc_align_chk #(
  parameter int OFF_W  = 3,
  parameter int SIZE_W = $clog2(OFF_W + 1)
) (
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              misaligned_o
);
  logic [OFF_W:0] span;

  always_comb begin
    span         = ((OFF_W+1)'(1) << size_i) - (OFF_W+1)'(1);
    misaligned_o = |(addr_lo_i & span[OFF_W-1:0]);
  end
endmodule

// File: rtl/mfc_perm_chk.sv
module mfc_perm_chk
  import mfc_pkg::*;
#(
  parameter int PROT_ENTRIES = 16
) (
  input  fault_cls_e cls_i,
  input  logic [1:0] priv_i,
  input  logic       hit_i,
  input  perm_t      perm_i,
  output logic       ok_o
);
  generate
    if (PROT_ENTRIES == 0) begin : g_open
      logic unused_perm;
      assign unused_perm = ^{cls_i, priv_i, hit_i, perm_i};
      assign ok_o = 1'b1;
    end else begin : g_check
      always_comb begin
        if (hit_i) begin
          unique case (cls_i)
            CLS_INSTR: ok_o = perm_i.x;
            CLS_LOAD:  ok_o = perm_i.r;
            default:   ok_o = perm_i.w;
          endcase
        end else begin
          // unmatched: only machine mode proceeds
          ok_o = (priv_i == PRIV_M);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mfc_cause_enc.sv
module mfc_cause_enc
  import mfc_pkg::*;
(
  input  fault_cls_e           cls_i,
  input  logic                 access_i,
  output logic [CAUSE_W-1:0]   cause_o
);
  always_comb begin
    unique case (cls_i)
      CLS_INSTR: cause_o = access_i ? CAUSE_I_ACC : CAUSE_I_MIS;
      CLS_LOAD:  cause_o = access_i ? CAUSE_L_ACC : CAUSE_L_MIS;
      default:   cause_o = access_i ? CAUSE_S_ACC : CAUSE_S_MIS;
    endcase
  end
endmodule

// File: rtl/mem_fault_classifier.sv
module mem_fault_classifier
  import mfc_pkg::*;
#(
  parameter int VA_W         = 39,
  parameter int OFF_W        = 3,
  parameter int PROT_ENTRIES = 16,
  localparam int SIZE_W      = $clog2(OFF_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2:0]         req_type_i,
  input  logic [1:0]         req_priv_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [SIZE_W-1:0]  req_size_i,
  input  logic               region_hit_i,
  input  logic               region_r_i,
  input  logic               region_w_i,
  input  logic               region_x_i,
  input  logic               region_non_idem_i,
  output logic               exc_valid_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [VA_W-1:0]    exc_tval_o
);
  acc_type_e            acc_type;
  fault_cls_e           cls;
  logic                 is_atomic;
  logic                 misaligned;
  logic                 perm_ok;
  logic                 no_emulate;
  logic                 fault_d;
  logic                 use_access;
  logic [CAUSE_W-1:0]   cause_d;
  perm_t                perm;

  always_comb begin
    acc_type  = acc_type_e'(req_type_i);
    is_atomic = 1'b0;
    unique case (acc_type)
      ACC_FETCH:       cls = CLS_INSTR;
      ACC_LOAD:        cls = CLS_LOAD;
      ACC_LR: begin
        cls       = CLS_LOAD;
        is_atomic = 1'b1;
      end
      ACC_SC, ACC_AMO: begin
        cls       = CLS_STORE;
        is_atomic = 1'b1;
      end
      default:         cls = CLS_STORE;
    endcase
    perm = '{r: region_r_i, w: region_w_i, x: region_x_i};
  end

  mfc_align_chk #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_align (
    .addr_lo_i    (req_vaddr_i[OFF_W-1:0]),
    .size_i       (req_size_i),
    .misaligned_o (misaligned)
  );

  mfc_perm_chk #(.PROT_ENTRIES(PROT_ENTRIES)) u_perm (
    .cls_i  (cls),
    .priv_i (req_priv_i),
    .hit_i  (region_hit_i),
    .perm_i (perm),
    .ok_o   (perm_ok)
  );

  // misaligned that software must not emulate becomes access-fault
  always_comb begin
    no_emulate = is_atomic | region_non_idem_i;
    fault_d    = req_valid_i & (misaligned | ~perm_ok);
    use_access = misaligned ? no_emulate : 1'b1;
  end

  mfc_cause_enc u_enc (
    .cls_i    (cls),
    .access_i (use_access),
    .cause_o  (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_o <= 1'b0;
      exc_cause_o <= '0;
      exc_tval_o  <= '0;
    end else begin
      exc_valid_o <= fault_d;
      if (fault_d) begin
        exc_cause_o <= cause_d;
        exc_tval_o  <= req_vaddr_i;
      end
    end
  end
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker
  import mfc_pkg::*;
#(
  parameter int VA_W         = 39,
  parameter int SIZE_W       = 2,
  parameter int PROT_ENTRIES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [2:0]         req_type_i,
  input logic [1:0]         req_priv_i,
  input logic [VA_W-1:0]    req_vaddr_i,
  input logic [SIZE_W-1:0]  req_size_i,
  input logic               region_hit_i,
  input logic               region_non_idem_i,
  input logic               exc_valid_o,
  input logic [CAUSE_W-1:0] exc_cause_o,
  input logic [VA_W-1:0]    exc_tval_o
);
  logic mis_c;
  logic atom_c;
  logic st_c;

  always_comb begin
    mis_c  = (req_vaddr_i % (VA_W'(1) << req_size_i)) != '0;
    atom_c = (req_type_i == 3'd2) || (req_type_i == 3'd4) || (req_type_i == 3'd5);
    st_c   = (req_type_i == 3'd3) || (req_type_i == 3'd4) || (req_type_i == 3'd5);
  end

  p_no_spurious_exc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> $past(req_valid_i));

  p_cause_legal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (exc_cause_o inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7}));

  p_tval_capture_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (exc_tval_o == $past(req_vaddr_i)));

  p_tval_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_o |-> $stable(exc_tval_o));

  p_plain_misalign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !atom_c && !region_non_idem_i && mis_c)
      |=> (exc_valid_o && (exc_cause_o inside {4'd0, 4'd4, 4'd6})));

  p_atomic_misalign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && atom_c && mis_c)
      |=> (exc_valid_o && (exc_cause_o inside {4'd5, 4'd7})));

  p_nonidem_misalign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && region_non_idem_i && mis_c)
      |=> (exc_valid_o && (exc_cause_o inside {4'd1, 4'd5, 4'd7})));

  p_store_class_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && st_c) |=> (!exc_valid_o || (exc_cause_o inside {4'd6, 4'd7})));

  p_mach_nomatch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_priv_i == 2'd3 && !region_hit_i && !mis_c) |=> !exc_valid_o);
endmodule

bind mem_fault_classifier mfc_checker #(
  .VA_W(VA_W), .SIZE_W(SIZE_W), .PROT_ENTRIES(PROT_ENTRIES)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_valid_i       (req_valid_i),
  .req_type_i        (req_type_i),
  .req_priv_i        (req_priv_i),
  .req_vaddr_i       (req_vaddr_i),
  .req_size_i        (req_size_i),
  .region_hit_i      (region_hit_i),
  .region_non_idem_i (region_non_idem_i),
  .exc_valid_o       (exc_valid_o),
  .exc_cause_o       (exc_cause_o),
  .exc_tval_o        (exc_tval_o)
);

// File: tb/mem_fault_classifier_tb.sv
module mem_fault_classifier_tb;
  localparam int VA_W = 39;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            v = 1'b0;
  logic [2:0]      ty = '0;
  logic [1:0]      pv = '0;
  logic [VA_W-1:0] va = '0;
  logic [1:0]      sz = '0;
  logic            hit = 1'b0, pr = 1'b0, pw = 1'b0, px = 1'b0, ni = 1'b0;

  logic            ev_a, ev_b;
  logic [3:0]      ec_a, ec_b;
  logic [VA_W-1:0] et_a, et_b;

  int              n_run = 0;
  int              n_fail = 0;
  bit              done = 1'b0;
  logic [3:0]      xc_a = '0, xc_b = '0;
  logic [VA_W-1:0] xt_a = '0, xt_b = '0;

  always #5 clk = ~clk;

  mem_fault_classifier #(.VA_W(VA_W), .PROT_ENTRIES(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_type_i(ty), .req_priv_i(pv),
    .req_vaddr_i(va), .req_size_i(sz), .region_hit_i(hit), .region_r_i(pr),
    .region_w_i(pw), .region_x_i(px), .region_non_idem_i(ni),
    .exc_valid_o(ev_a), .exc_cause_o(ec_a), .exc_tval_o(et_a));

  mem_fault_classifier #(.VA_W(VA_W), .PROT_ENTRIES(0)) u_dut_open (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_type_i(ty), .req_priv_i(pv),
    .req_vaddr_i(va), .req_size_i(sz), .region_hit_i(hit), .region_r_i(pr),
    .region_w_i(pw), .region_x_i(px), .region_non_idem_i(ni),
    .exc_valid_o(ev_b), .exc_cause_o(ec_b), .exc_tval_o(et_b));

  function automatic void model(input bit prot, output bit exc, output logic [3:0] cause,
                                output string tag);
    logic [3:0] mis_code;
    bit         mis, atom, ok;
    int         cls;
    cls  = (ty == 3'd0) ? 0 : ((ty == 3'd1 || ty == 3'd2) ? 1 : 2);
    mis_code = (cls == 0) ? 4'd0 : ((cls == 1) ? 4'd4 : 4'd6);
    mis  = (va % (VA_W'(1) << sz)) != 0;
    atom = (ty == 3'd2 || ty == 3'd4 || ty == 3'd5);
    if (!prot) ok = 1'b1;
    else if (!hit) ok = (pv == 2'd3);
    else ok = (cls == 0) ? px : ((cls == 1) ? pr : pw);
    exc = 1'b0; cause = 4'd0; tag = "R1";
    if (!v) begin
      tag = "R1";
    end else if (mis && atom) begin
      exc = 1'b1; cause = mis_code + 4'd1; tag = "R4";
    end else if (mis && ni) begin
      exc = 1'b1; cause = mis_code + 4'd1; tag = "R5";
    end else if (mis) begin
      exc = 1'b1; cause = mis_code; tag = "R2/R3";
    end else if (!ok) begin
      exc = 1'b1; cause = mis_code + 4'd1;
      tag = !hit ? "R9" : ((cls == 0) ? "R6" : ((cls == 1) ? "R7" : "R8"));
    end
    if (!prot) tag = {tag, " R10"};
  endfunction

  task automatic chk(input string who, input string tag, input logic ev, input logic [3:0] ec,
                     input logic [VA_W-1:0] et, input bit xv, input logic [3:0] xc,
                     input logic [VA_W-1:0] xt);
    n_run++;
    if (ev !== xv || ec !== xc || et !== xt) begin
      n_fail++;
      $display("FAIL %s %s R12 R11: got v=%0b cause=%0d tval=%h exp v=%0b cause=%0d tval=%h",
               who, tag, ev, ec, et, xv, xc, xt);
    end
  endtask

  task automatic step(input bit vv, input logic [2:0] t, input logic [1:0] p,
                      input logic [VA_W-1:0] a, input logic [1:0] s, input bit h,
                      input bit r, input bit w, input bit x, input bit n);
    bit         xa, xb;
    logic [3:0] ca, cb;
    string      ta, tb;
    @(negedge clk);
    v = vv; ty = t; pv = p; va = a; sz = s; hit = h; pr = r; pw = w; px = x; ni = n;
    model(1'b1, xa, ca, ta);
    model(1'b0, xb, cb, tb);
    if (xa) begin xc_a = ca; xt_a = a; end
    if (xb) begin xc_b = cb; xt_b = a; end
    @(posedge clk);
    #1;
    chk("u_dut", ta, ev_a, ec_a, et_a, xa, xc_a, xt_a);
    chk("u_dut_open", tb, ev_b, ec_b, et_b, xb, xc_b, xt_b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #2;
    // R1 R11 reset state
    chk("u_dut", "R1 reset", ev_a, ec_a, et_a, 1'b0, 4'd0, '0);
    chk("u_dut_open", "R1 reset", ev_b, ec_b, et_b, 1'b0, 4'd0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // directed corners (kinds: 0 fetch,1 load,2 LR,3 store,4 SC,5 AMO)
    step(1, 3'd2, 2'd1, 39'h10_0002, 2'd2, 1, 0, 1, 1, 0); // R4 misaligned LR + no read -> 5
    step(1, 3'd5, 2'd0, 39'h00_0004, 2'd3, 1, 1, 1, 1, 0); // R4 AMO -> 7
    step(1, 3'd4, 2'd3, 39'h00_0006, 2'd2, 1, 1, 0, 1, 0); // R4 SC -> 7
    step(1, 3'd1, 2'd1, 39'h00_0001, 2'd2, 1, 1, 1, 1, 0); // R3 load -> 4
    step(1, 3'd3, 2'd0, 39'h00_0001, 2'd1, 1, 1, 0, 1, 0); // R3 store priority -> 6
    step(1, 3'd0, 2'd0, 39'h00_0002, 2'd2, 1, 1, 1, 0, 0); // R3 fetch -> 0
    step(1, 3'd1, 2'd3, 39'h00_0002, 2'd3, 1, 1, 1, 1, 1); // R5 load non-idem -> 5
    step(1, 3'd0, 2'd1, 39'h00_0001, 2'd1, 1, 1, 1, 1, 1); // R5 fetch non-idem -> 1
    step(1, 3'd0, 2'd1, 39'h00_1000, 2'd2, 1, 1, 1, 0, 0); // R6 -> 1
    step(1, 3'd2, 2'd0, 39'h00_2008, 2'd3, 1, 0, 1, 1, 0); // R7 LR -> 5
    step(1, 3'd4, 2'd0, 39'h00_3000, 2'd2, 1, 1, 0, 1, 0); // R8 SC -> 7
    step(1, 3'd1, 2'd1, 39'h00_4000, 2'd2, 0, 1, 1, 1, 0); // R9 S no match -> 5, R10 open none
    step(1, 3'd3, 2'd0, 39'h00_4010, 2'd2, 0, 1, 1, 1, 0); // R9 U no match -> 7
    step(1, 3'd1, 2'd3, 39'h00_5000, 2'd3, 0, 0, 0, 0, 0); // R9 M no match -> none
    step(1, 3'd1, 2'd1, 39'h00_5003, 2'd0, 1, 1, 1, 1, 1); // R2 byte at odd address -> none
    step(0, 3'd2, 2'd0, 39'h00_6001, 2'd3, 0, 0, 0, 0, 1); // R1 no request -> none, R11 tval holds
    step(1, 3'd5, 2'd0, 39'h7F_FFFF_FFF8, 2'd3, 1, 1, 1, 1, 0); // R11 clean high address

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [VA_W-1:0] a;
      logic [1:0]      p;
      a = VA_W'({$urandom, $urandom});
      if ($urandom % 2 == 0) a[2:0] = 3'd0;
      p = ($urandom % 3 == 2) ? 2'd3 : 2'($urandom % 2);
      step(($urandom % 8) != 0, 3'($urandom % 6), p, a, 2'($urandom % 4),
           ($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule